// File: doc/BRIEF.md
# Two-Phase Clock Offset and Delay Corrector

This block keeps time on the slave side of a network time-transfer link. It holds a free-running nanosecond counter that grows by a programmable increment on every clock cycle. It corrects that counter against a remote master in two phases, using event strobes that arrive together with timestamps and sequence numbers.

In the first phase, a sync arrival captures the local time. The matching follow-up then supplies the master's transmit time. The difference between the two is the combined offset plus transit delay, and the counter is stepped back by all of it. In the second phase, a fresh sync pair is timestamped on the corrected clock, and its difference gives the master-to-slave delay. A delay request, whose transmit time is captured locally, and its matching response, which carries the master's arrival time, give the slave-to-master delay. The two directional delays are averaged, and the counter is moved forward by the mean. A new sync after completion starts the whole sequence again, so that periodic repetition follows the drift between the two clocks.

Top module: `ts_two_phase_sync`

## Requirements
- R1: After reset, `local_time`, `offset`, `mean_delay` and `done` are zero, and `phase` is 0 (IDLE).
- R2: In any cycle with no correction, `local_time` grows by exactly `incr` at each clock edge.
- R3: A `sync_stb` seen in phase IDLE (0) or DONE (5) captures the current `local_time` and its sequence number, and moves `phase` to WAIT_FOLLOWUP_1 (1).
- R4: In phase 1, a `fup_stb` whose `fup_seq` equals the captured sequence number sets `offset` to the signed value (captured time − `fup_ts`). At the same edge, the counter becomes old time + `incr` − offset, with no tick lost, and `phase` moves to WAIT_SYNC_2 (2).
- R5: A follow-up or delay response whose sequence number does not match the pending one is ignored: `phase`, `offset` and `mean_delay` stay the same, and the counter only advances by `incr`.
- R6: In phase 2, a sync captures the time and moves to WAIT_FOLLOWUP_2 (3). A matching follow-up there records the master-to-slave delay (captured time − `fup_ts`) without stepping the clock, and moves to WAIT_DELAY_RESP (4).
- R7: In phase 4, `dreq_stb` captures the current `local_time` and `dreq_seq`. A `dresp_stb` with an equal sequence number forms the slave-to-master delay (`dresp_ts` − captured time). `mean_delay` becomes the sum of the two delays shifted right arithmetically by one, the counter becomes old time + `incr` + mean, and `phase` moves to DONE (5).
- R8: `done` is high for exactly one cycle, the cycle in which `phase` first shows DONE.
- R9: A sync in phase DONE starts a new correction cycle exactly as it does from IDLE.
- R10: In phase 4, a delay response that arrives before any delay request has been captured is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| incr | input | INC_W | Nanoseconds added to the counter each cycle |
| sync_stb | input | 1 | Sync arrival event |
| sync_seq | input | SEQ_W | Sequence number of the sync |
| fup_stb | input | 1 | Follow-up arrival event |
| fup_seq | input | SEQ_W | Sequence number of the follow-up |
| fup_ts | input | 64 | Master transmit time carried by the follow-up |
| dreq_stb | input | 1 | Local delay request transmitted |
| dreq_seq | input | SEQ_W | Sequence number of the delay request |
| dresp_stb | input | 1 | Delay response arrival event |
| dresp_seq | input | SEQ_W | Sequence number of the delay response |
| dresp_ts | input | 64 | Master arrival time of the request |
| local_time | output | 64 | Current local nanosecond time |
| offset | output | 64 | Last measured offset plus transit, signed |
| mean_delay | output | 64 | Last mean path delay, signed |
| phase | output | 3 | Correction phase, encoded 0 to 5 |
| done | output | 1 | One-cycle pulse at the end of each correction cycle |

## Verification
The assertions check on every cycle the behaviour that holds cycle by cycle: the plain tick advance, the exact size of both step corrections relative to the published offset and mean, that each waiting phase is held until its matching event arrives, and the shape of the done pulse. The bench scenarios are needed for the behaviour that depends on a sequence of events. These are the arithmetic of a whole exchange against timestamps it builds itself, rejection of mismatched or early messages, rounding toward minus infinity of a negative odd delay sum, and a second correction cycle started from DONE.

// File: rtl/ts_pkg.sv
package ts_pkg;

  localparam int TS_W = 64;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_WAIT_FUP1  = 3'd1,
    PH_WAIT_SYNC2 = 3'd2,
    PH_WAIT_FUP2  = 3'd3,
    PH_WAIT_DRESP = 3'd4,
    PH_DONE       = 3'd5
  } phase_t;

  // signed difference of two unsigned timestamps, wrapping at 2^64
  function automatic logic signed [TS_W-1:0] ts_diff(
    input logic [TS_W-1:0] later,
    input logic [TS_W-1:0] earlier
  );
    return signed'(later - earlier);
  endfunction

  // sum of two signed delays, arithmetic shift right by one (floor of the mean)
  function automatic logic signed [TS_W-1:0] ts_mean(
    input logic signed [TS_W-1:0] a,
    input logic signed [TS_W-1:0] b
  );
    logic signed [TS_W:0] s;
    s = {a[TS_W-1], a} + {b[TS_W-1], b};
    return s[TS_W:1];
  endfunction

  // one counter tick with an optional signed adjustment in the same cycle
  function automatic logic [TS_W-1:0] ts_advance(
    input logic [TS_W-1:0]        t,
    input logic [TS_W-1:0]        inc,
    input logic signed [TS_W-1:0] adj
  );
    return t + inc + unsigned'(adj);
  endfunction

endpackage

// File: rtl/ts_time_counter.sv
module ts_time_counter
  import ts_pkg::*;
#(
  parameter int INC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [INC_W-1:0]       incr,
  input  logic                   adj_en,
  input  logic signed [TS_W-1:0] adj,
  output logic [TS_W-1:0]        time_q
);

  localparam int PAD_W = TS_W - INC_W;

  logic [TS_W-1:0]        inc_ext;
  logic signed [TS_W-1:0] adj_eff;
  logic [TS_W-1:0]        time_d;

  always_comb begin
    inc_ext = {{PAD_W{1'b0}}, incr};
    adj_eff = adj_en ? adj : '0;
    time_d  = ts_advance(time_q, inc_ext, adj_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

endmodule

// File: rtl/ts_delay_avg.sv
module ts_delay_avg
  import ts_pkg::*;
(
  input  logic signed [TS_W-1:0] ms_delay,
  input  logic signed [TS_W-1:0] sm_delay,
  output logic signed [TS_W-1:0] mean
);

  always_comb mean = ts_mean(ms_delay, sm_delay);

endmodule

// File: rtl/ts_phase_fsm.sv
module ts_phase_fsm
  import ts_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        local_time,
  input  logic                   sync_stb,
  input  logic [SEQ_W-1:0]       sync_seq,
  input  logic                   fup_stb,
  input  logic [SEQ_W-1:0]       fup_seq,
  input  logic [TS_W-1:0]        fup_ts,
  input  logic                   dreq_stb,
  input  logic [SEQ_W-1:0]       dreq_seq,
  input  logic                   dresp_stb,
  input  logic [SEQ_W-1:0]       dresp_seq,
  input  logic [TS_W-1:0]        dresp_ts,
  output phase_t                 phase_q,
  output logic                   sync_accept,
  output logic                   offset_fire,
  output logic                   ms_fire,
  output logic                   dreq_accept,
  output logic                   delay_fire,
  output logic signed [TS_W-1:0] fup_diff,
  output logic signed [TS_W-1:0] ms_delay_q,
  output logic signed [TS_W-1:0] sm_delay
);

  phase_t           phase_d;
  logic [TS_W-1:0]  rx_q;
  logic [SEQ_W-1:0] seq_pend_q;
  logic             req_sent_q;
  logic [TS_W-1:0]  req_tx_q;
  logic [SEQ_W-1:0] req_seq_q;
  logic             fup_match;
  logic             sync_window;

  always_comb begin
    sync_window = (phase_q == PH_IDLE) || (phase_q == PH_DONE) ||
                  (phase_q == PH_WAIT_SYNC2);
    sync_accept = sync_stb && sync_window;
    fup_match   = fup_stb && (fup_seq == seq_pend_q);
    offset_fire = fup_match && (phase_q == PH_WAIT_FUP1);
    ms_fire     = fup_match && (phase_q == PH_WAIT_FUP2);
    dreq_accept = dreq_stb && (phase_q == PH_WAIT_DRESP);
    delay_fire  = dresp_stb && (phase_q == PH_WAIT_DRESP) && req_sent_q &&
                  (dresp_seq == req_seq_q);
    fup_diff    = ts_diff(rx_q, fup_ts);
    sm_delay    = ts_diff(dresp_ts, req_tx_q);
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE, PH_DONE: if (sync_accept) phase_d = PH_WAIT_FUP1;
      PH_WAIT_FUP1:     if (offset_fire) phase_d = PH_WAIT_SYNC2;
      PH_WAIT_SYNC2:    if (sync_accept) phase_d = PH_WAIT_FUP2;
      PH_WAIT_FUP2:     if (ms_fire)     phase_d = PH_WAIT_DRESP;
      PH_WAIT_DRESP:    if (delay_fire)  phase_d = PH_DONE;
      default:          phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      rx_q       <= '0;
      seq_pend_q <= '0;
      ms_delay_q <= '0;
      req_sent_q <= 1'b0;
      req_tx_q   <= '0;
      req_seq_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (sync_accept) begin
        rx_q       <= local_time;
        seq_pend_q <= sync_seq;
      end
      if (ms_fire) begin
        ms_delay_q <= fup_diff;
        req_sent_q <= 1'b0;
      end
      if (dreq_accept) begin
        req_sent_q <= 1'b1;
        req_tx_q   <= local_time;
        req_seq_q  <= dreq_seq;
      end
    end
  end

endmodule

// File: rtl/ts_two_phase_sync.sv
module ts_two_phase_sync
  import ts_pkg::*;
#(
  parameter int INC_W = 32,
  parameter int SEQ_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INC_W-1:0]   incr,
  input  logic               sync_stb,
  input  logic [SEQ_W-1:0]   sync_seq,
  input  logic               fup_stb,
  input  logic [SEQ_W-1:0]   fup_seq,
  input  logic [63:0]        fup_ts,
  input  logic               dreq_stb,
  input  logic [SEQ_W-1:0]   dreq_seq,
  input  logic               dresp_stb,
  input  logic [SEQ_W-1:0]   dresp_seq,
  input  logic [63:0]        dresp_ts,
  output logic [63:0]        local_time,
  output logic [63:0]        offset,
  output logic [63:0]        mean_delay,
  output logic [2:0]         phase,
  output logic               done
);

  phase_t                 phase_w;
  logic                   sync_accept;
  logic                   offset_fire;
  logic                   ms_fire;
  logic                   dreq_accept;
  logic                   delay_fire;
  logic signed [TS_W-1:0] fup_diff;
  logic signed [TS_W-1:0] ms_delay;
  logic signed [TS_W-1:0] sm_delay;
  logic signed [TS_W-1:0] mean_w;
  logic                   adj_en;
  logic signed [TS_W-1:0] adj_w;
  logic [TS_W-1:0]        time_w;
  logic signed [TS_W-1:0] offset_q;
  logic signed [TS_W-1:0] mean_q;
  logic                   done_q;

  ts_phase_fsm #(.SEQ_W(SEQ_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .local_time (time_w),
    .sync_stb   (sync_stb),
    .sync_seq   (sync_seq),
    .fup_stb    (fup_stb),
    .fup_seq    (fup_seq),
    .fup_ts     (fup_ts),
    .dreq_stb   (dreq_stb),
    .dreq_seq   (dreq_seq),
    .dresp_stb  (dresp_stb),
    .dresp_seq  (dresp_seq),
    .dresp_ts   (dresp_ts),
    .phase_q    (phase_w),
    .sync_accept(sync_accept),
    .offset_fire(offset_fire),
    .ms_fire    (ms_fire),
    .dreq_accept(dreq_accept),
    .delay_fire (delay_fire),
    .fup_diff   (fup_diff),
    .ms_delay_q (ms_delay),
    .sm_delay   (sm_delay)
  );

  ts_delay_avg u_avg (
    .ms_delay(ms_delay),
    .sm_delay(sm_delay),
    .mean    (mean_w)
  );

  // offset phase steps back by the whole difference; delay phase steps forward by the mean
  always_comb begin
    adj_en = offset_fire || delay_fire;
    adj_w  = offset_fire ? -fup_diff : mean_w;
  end

  ts_time_counter #(.INC_W(INC_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .incr  (incr),
    .adj_en(adj_en),
    .adj   (adj_w),
    .time_q(time_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      mean_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      if (offset_fire) offset_q <= fup_diff;
      if (delay_fire)  mean_q   <= mean_w;
      done_q <= delay_fire;
    end
  end

  assign local_time = time_w;
  assign offset     = offset_q;
  assign mean_delay = mean_q;
  assign phase      = phase_w;
  assign done       = done_q;

endmodule

// File: rtl/ts_two_phase_sync_chk.sv
module ts_two_phase_sync_chk
  import ts_pkg::*;
#(
  parameter int INC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [INC_W-1:0] incr,
  input logic [63:0]      local_time,
  input logic [63:0]      offset,
  input logic [63:0]      mean_delay,
  input logic [2:0]       phase,
  input logic             done,
  input logic             sync_accept,
  input logic             offset_fire,
  input logic             dreq_accept,
  input logic             delay_fire
);

  localparam int PAD_W = 64 - INC_W;

  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(offset_fire || delay_fire) |=>
      local_time == $past(local_time) + {{PAD_W{1'b0}}, $past(incr)});

  p_sync_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_accept && (phase == PH_IDLE || phase == PH_DONE)) |=> phase == PH_WAIT_FUP1);

  p_offset_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    offset_fire |=>
      local_time == $past(local_time) + {{PAD_W{1'b0}}, $past(incr)} - offset);

  p_hold_fup1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT_FUP1 && !offset_fire) |=> (phase == PH_WAIT_FUP1 && $stable(offset)));

  p_hold_dresp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT_DRESP && !delay_fire) |=>
      (phase == PH_WAIT_DRESP && $stable(mean_delay)));

  p_delay_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    delay_fire |=>
      local_time == $past(local_time) + {{PAD_W{1'b0}}, $past(incr)} + mean_delay);

  p_dreq_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_accept |-> phase == PH_WAIT_DRESP);

  p_done_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase == PH_DONE);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_phase_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd5);

endmodule

bind ts_two_phase_sync ts_two_phase_sync_chk #(.INC_W(INC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .incr       (incr),
  .local_time (local_time),
  .offset     (offset),
  .mean_delay (mean_delay),
  .phase      (phase),
  .done       (done),
  .sync_accept(sync_accept),
  .offset_fire(offset_fire),
  .dreq_accept(dreq_accept),
  .delay_fire (delay_fire)
);

// File: tb/sim_ts_two_phase_sync.sv
`timescale 1ns/1ps
module sim_ts_two_phase_sync;

  localparam int INC_W = 32;
  localparam int SEQ_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [INC_W-1:0] incr = 32'd8;
  logic             sync_stb = 1'b0;
  logic [SEQ_W-1:0] sync_seq = '0;
  logic             fup_stb = 1'b0;
  logic [SEQ_W-1:0] fup_seq = '0;
  logic [63:0]      fup_ts = '0;
  logic             dreq_stb = 1'b0;
  logic [SEQ_W-1:0] dreq_seq = '0;
  logic             dresp_stb = 1'b0;
  logic [SEQ_W-1:0] dresp_seq = '0;
  logic [63:0]      dresp_ts = '0;
  logic [63:0]      local_time;
  logic [63:0]      offset;
  logic [63:0]      mean_delay;
  logic [2:0]       phase;
  logic             done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ts_two_phase_sync #(.INC_W(INC_W), .SEQ_W(SEQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .incr(incr),
    .sync_stb(sync_stb), .sync_seq(sync_seq),
    .fup_stb(fup_stb), .fup_seq(fup_seq), .fup_ts(fup_ts),
    .dreq_stb(dreq_stb), .dreq_seq(dreq_seq),
    .dresp_stb(dresp_stb), .dresp_seq(dresp_seq), .dresp_ts(dresp_ts),
    .local_time(local_time), .offset(offset), .mean_delay(mean_delay),
    .phase(phase), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // event helpers: drive at a falling edge, return time seen before the capturing edge
  task automatic do_sync(input logic [15:0] s, output logic [63:0] t_before, output logic [63:0] t_after);
    @(negedge clk); t_before = local_time; sync_stb = 1'b1; sync_seq = s;
    @(negedge clk); sync_stb = 1'b0; t_after = local_time;
  endtask

  task automatic do_fup(input logic [15:0] s, input logic [63:0] ts, output logic [63:0] t_before, output logic [63:0] t_after);
    @(negedge clk); t_before = local_time; fup_stb = 1'b1; fup_seq = s; fup_ts = ts;
    @(negedge clk); fup_stb = 1'b0; t_after = local_time;
  endtask

  task automatic do_dreq(input logic [15:0] s, output logic [63:0] t_before);
    @(negedge clk); t_before = local_time; dreq_stb = 1'b1; dreq_seq = s;
    @(negedge clk); dreq_stb = 1'b0;
  endtask

  task automatic do_dresp(input logic [15:0] s, input logic [63:0] ts, output logic [63:0] t_before, output logic [63:0] t_after);
    @(negedge clk); t_before = local_time; dresp_stb = 1'b1; dresp_seq = s; dresp_ts = ts;
    @(negedge clk); dresp_stb = 1'b0; t_after = local_time;
  endtask

  task automatic t_reset;
    chk("R1 local_time", local_time, 64'd0);
    chk("R1 offset", offset, 64'd0);
    chk("R1 mean_delay", mean_delay, 64'd0);
    chk("R1 phase", {61'd0, phase}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
  endtask

  task automatic t_tick;
    logic [63:0] a;
    @(negedge clk); a = local_time;
    @(negedge clk); chk("R2 tick by 8", local_time, a + 64'd8);
    incr = 32'd5;
    @(negedge clk); a = local_time;
    @(negedge clk); chk("R2 tick by 5", local_time, a + 64'd5);
  endtask

  task automatic t_cycle_one;
    logic [63:0] rx, b, a, rx2, tx;
    do_sync(16'd7, rx, a);
    chk("R3 phase after sync", {61'd0, phase}, 64'd1);
    do_fup(16'd8, rx - 64'd1000, b, a);
    chk("R5 bad fup phase", {61'd0, phase}, 64'd1);
    chk("R5 bad fup offset", offset, 64'd0);
    chk("R5 bad fup no step", a, b + 64'd5);
    do_fup(16'd7, rx - 64'd1000, b, a);
    chk("R4 offset value", offset, 64'd1000);
    chk("R4 clock step", a, b + 64'd5 - 64'd1000);
    chk("R4 phase", {61'd0, phase}, 64'd2);
    do_sync(16'd9, rx2, a);
    chk("R6 phase after sync2", {61'd0, phase}, 64'd3);
    do_fup(16'd9, rx2 - 64'd40, b, a);
    chk("R6 no step on second pair", a, b + 64'd5);
    chk("R6 phase wait resp", {61'd0, phase}, 64'd4);
    do_dresp(16'd3, 64'd0, b, a);
    chk("R10 early resp phase", {61'd0, phase}, 64'd4);
    chk("R10 early resp no step", a, b + 64'd5);
    do_dreq(16'd3, tx);
    do_dresp(16'd4, tx + 64'd70, b, a);
    chk("R5 bad resp phase", {61'd0, phase}, 64'd4);
    chk("R5 bad resp mean", mean_delay, 64'd0);
    do_dresp(16'd3, tx + 64'd70, b, a);
    chk("R7 mean value", mean_delay, 64'd55);
    chk("R7 clock step", a, b + 64'd5 + 64'd55);
    chk("R7 phase done", {61'd0, phase}, 64'd5);
    chk("R8 done high", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R8 done drops", {63'd0, done}, 64'd0);
  endtask

  task automatic t_cycle_two;
    logic [63:0] rx, b, a, rx2, tx;
    do_sync(16'd20, rx, a);
    chk("R9 restart from done", {61'd0, phase}, 64'd1);
    do_fup(16'd20, rx + 64'd300, b, a);
    chk("R4 negative offset", offset, -64'sd300);
    chk("R4 forward step", a, b + 64'd5 + 64'd300);
    do_sync(16'd21, rx2, a);
    do_fup(16'd21, rx2 + 64'd3, b, a);
    do_dreq(16'd5, tx);
    do_dresp(16'd5, tx, b, a);
    chk("R7 negative odd mean floors", mean_delay, -64'sd2);
    chk("R7 backward step", a, b + 64'd5 - 64'd2);
    chk("R8 done second cycle", {63'd0, done}, 64'd1);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_tick();
    t_cycle_one();
    t_cycle_two();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule